// File: doc/BRIEF.md
# Slot-Based PCI Interrupt Router

This block takes an interrupt event from a PCI slot, identified by slot number and interrupt pin index (0 to 3), and converts it into an internal interrupt number using a hard-wired slot table. Mapped numbers start at a base of 32. A multifunction device slot gets one number per pin. Two single-function slots share one number across all their pins. The add-in slots rotate the pin index by slot position. Any slot outside the table passes its pin index through unchanged.

The internal index is the mapped number minus the base. It selects one bit from each of two 32-bit configuration words, one for edge mode and one for polarity. These bits decide how a level-change strobe drives the single upstream interrupt line.

In edge mode the line gives a one-cycle pulse and then returns low. In level mode the line takes the polarity bit and keeps that value until the next strobe. The mapped number is presented combinationally. The line is registered.

Top module: `irq_slot_router`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `irqLine` is 0.
- R2: Slot 5 maps pin n (0 to 3) to 32 + n on `irqNum`.
- R3: Slot 6 maps every pin to 36. Slot 7 maps every pin to 37.
- R4: Slots 8 through 12 map pin n to 38 + (slot − 8) + n, so slot 12 pin 3 gives 45.
- R5: Slots 0 to 4 and 13 to 31 put the pin index itself on `irqNum`, with no translation.
- R6: Edge mode is selected when bit (irqNum − 32) of `edgeCfg` is 1. A strobe sampled at a clock edge makes `irqLine` 1 for exactly the following cycle. If no further strobe arrives, the line is 0 in the cycle after that.
- R7: Level mode is selected when that `edgeCfg` bit is 0. A strobe sampled at a clock edge sets `irqLine` to bit (irqNum − 32) of `polCfg` for the following cycle. The line keeps that value until the next in-range strobe, even if `polCfg` changes in the meantime.
- R8: When irqNum − 32 falls outside 0 to 31, which covers every untranslated slot, a strobe does not change `irqLine`.
- R9: A level-mode strobe in the pulse cycle of an edge event replaces the pulse. The line then holds the new polarity value rather than dropping to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slotNum | input | 5 | Slot number of the requesting device |
| pinIdx | input | 2 | Interrupt pin index of the device, 0 to 3 |
| evtStrobe | input | 1 | One-cycle strobe signalling a level change on the selected pin |
| edgeCfg | input | 32 | Per-index edge-mode select, where 1 means pulse |
| polCfg | input | 32 | Per-index level value used in level mode |
| irqNum | output | 8 | Mapped interrupt number |
| irqLine | output | 1 | Upstream interrupt line |

## Verification
A table covers the mapping. It includes both ends of the pin range on every mapped slot, and the first, a middle and the last add-in slot. These points separate a wrong rotation offset from a wrong slot base. It also includes untranslated slots on each side of the table and at slot 31, which expose any leak of the base offset.

Directed sequences then check the line behaviour:
- An edge event is checked in its pulse cycle and in the cycle after, which catches pulses that are too long or that are missing.
- A level event is followed by idle cycles and by a `polCfg` change made without a strobe, which separates holding from following the configuration.
- Strobes from out-of-range slots are applied while the line is both high and low.
- A level strobe is placed directly after an edge strobe to show that the override wins over the pulse end.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
  localparam int IRQ_BASE_DEF  = 32;
  localparam int MULTI_SLOT    = 5;
  localparam int SHARED_SLOT_A = 6;
  localparam int SHARED_SLOT_B = 7;
  localparam int ADDIN_FIRST   = 8;
  localparam int ADDIN_LAST    = 12;
  localparam int SHARED_OFS_A  = 4;
  localparam int SHARED_OFS_B  = 5;
  localparam int ADDIN_OFS     = 6;

  // Strobes from control to the line datapath
  typedef struct packed {
    logic pulse;
    logic level;
    logic levelVal;
  } irqCmd_t;
endpackage

// File: rtl/irqr_map.sv
module irqr_map
  import irqr_pkg::*;
#(
  parameter int SLOT_W   = 5,
  parameter int PIN_W    = 2,
  parameter int NUM_W    = 8,
  parameter int BASE_NUM = IRQ_BASE_DEF
) (
  input  logic [SLOT_W-1:0] slotNum,
  input  logic [PIN_W-1:0]  pinIdx,
  output logic [NUM_W-1:0]  irqNum
);
  localparam int ADDIN_CNT = ADDIN_LAST - ADDIN_FIRST + 1;

  logic [ADDIN_CNT-1:0] addinHit;
  logic [NUM_W-1:0]     addinNum [ADDIN_CNT];
  logic [NUM_W-1:0]     pinExt;

  // The pin field is PIN_W bits wide, so the modulo-4 wrap on the multifunction slot is implicit
  assign pinExt = NUM_W'(pinIdx);

  for (genvar g = 0; g < ADDIN_CNT; g++) begin : g_addin
    assign addinHit[g] = (slotNum == SLOT_W'(ADDIN_FIRST + g));
    assign addinNum[g] = NUM_W'(BASE_NUM + ADDIN_OFS + g) + pinExt;
  end

  always_comb begin
    irqNum = pinExt;
    if (slotNum == SLOT_W'(MULTI_SLOT))
      irqNum = NUM_W'(BASE_NUM) + pinExt;
    else if (slotNum == SLOT_W'(SHARED_SLOT_A))
      irqNum = NUM_W'(BASE_NUM + SHARED_OFS_A);
    else if (slotNum == SLOT_W'(SHARED_SLOT_B))
      irqNum = NUM_W'(BASE_NUM + SHARED_OFS_B);
    else begin
      for (int i = 0; i < ADDIN_CNT; i++)
        if (addinHit[i]) irqNum = addinNum[i];
    end
  end
endmodule

// File: rtl/irqr_ctrl.sv
module irqr_ctrl
  import irqr_pkg::*;
#(
  parameter int NUM_W    = 8,
  parameter int CFG_W    = 32,
  parameter int BASE_NUM = IRQ_BASE_DEF
) (
  input  logic [NUM_W-1:0] irqNum,
  input  logic             evtStrobe,
  input  logic [CFG_W-1:0] edgeCfg,
  input  logic [CFG_W-1:0] polCfg,
  output irqCmd_t          cmd
);
  localparam int IDX_W = $clog2(CFG_W);

  logic [NUM_W-1:0] offset;
  logic             inRange;
  logic [IDX_W-1:0] idx;

  assign offset  = irqNum - NUM_W'(BASE_NUM);
  assign inRange = (irqNum >= NUM_W'(BASE_NUM)) && (offset < NUM_W'(CFG_W));
  assign idx     = offset[IDX_W-1:0];

  always_comb begin
    cmd          = '0;
    cmd.levelVal = polCfg[idx];
    if (evtStrobe && inRange) begin
      cmd.pulse = edgeCfg[idx];
      cmd.level = ~edgeCfg[idx];
    end
  end
endmodule

// File: rtl/irqr_line.sv
module irqr_line
  import irqr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  irqCmd_t cmd,
  output logic    irqLine
);
  logic lineQ;
  logic pulseQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lineQ  <= 1'b0;
      pulseQ <= 1'b0;
    end else if (cmd.pulse) begin
      lineQ  <= 1'b1;
      pulseQ <= 1'b1;
    end else if (cmd.level) begin
      lineQ  <= cmd.levelVal;
      pulseQ <= 1'b0;
    end else if (pulseQ) begin
      lineQ  <= 1'b0;
      pulseQ <= 1'b0;
    end
  end

  assign irqLine = lineQ;
endmodule

// File: rtl/irq_slot_router.sv
module irq_slot_router
  import irqr_pkg::*;
#(
  parameter int SLOT_W   = 5,
  parameter int PIN_W    = 2,
  parameter int NUM_W    = 8,
  parameter int CFG_W    = 32,
  parameter int BASE_NUM = IRQ_BASE_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] slotNum,
  input  logic [PIN_W-1:0]  pinIdx,
  input  logic              evtStrobe,
  input  logic [CFG_W-1:0]  edgeCfg,
  input  logic [CFG_W-1:0]  polCfg,
  output logic [NUM_W-1:0]  irqNum,
  output logic              irqLine
);
  irqCmd_t cmd;

  irqr_map #(.SLOT_W(SLOT_W), .PIN_W(PIN_W), .NUM_W(NUM_W), .BASE_NUM(BASE_NUM)) u_map (
    .slotNum(slotNum), .pinIdx(pinIdx), .irqNum(irqNum));

  irqr_ctrl #(.NUM_W(NUM_W), .CFG_W(CFG_W), .BASE_NUM(BASE_NUM)) u_ctrl (
    .irqNum(irqNum), .evtStrobe(evtStrobe), .edgeCfg(edgeCfg), .polCfg(polCfg), .cmd(cmd));

  irqr_line u_line (.clk(clk), .rst_n(rst_n), .cmd(cmd), .irqLine(irqLine));
endmodule

// File: rtl/irqr_chk.sv
module irqr_chk #(
  parameter int SLOT_W   = 5,
  parameter int PIN_W    = 2,
  parameter int NUM_W    = 8,
  parameter int CFG_W    = 32,
  parameter int BASE_NUM = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SLOT_W-1:0] slotNum,
  input logic [PIN_W-1:0]  pinIdx,
  input logic              evtStrobe,
  input logic [CFG_W-1:0]  edgeCfg,
  input logic [CFG_W-1:0]  polCfg,
  input logic [NUM_W-1:0]  irqNum,
  input logic              irqLine
);
  localparam int IDX_W = $clog2(CFG_W);

  logic [NUM_W-1:0] chkOfs;
  logic             chkIn;
  logic [IDX_W-1:0] chkIdx;
  logic             untranslated;

  assign chkOfs       = irqNum - NUM_W'(BASE_NUM);
  assign chkIn        = (irqNum >= NUM_W'(BASE_NUM)) && (chkOfs < NUM_W'(CFG_W));
  assign chkIdx       = chkOfs[IDX_W-1:0];
  assign untranslated = (slotNum < SLOT_W'(5)) || (slotNum > SLOT_W'(12));

  AST_RESET_LOW: assert property (@(posedge clk) !rst_n |=> !irqLine); // R1

  AST_SHARED_A: assert property (@(posedge clk) disable iff (!rst_n)
    slotNum == SLOT_W'(6) |-> irqNum == NUM_W'(BASE_NUM + 4)); // R3

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    untranslated |-> irqNum == NUM_W'(pinIdx)); // R5

  AST_EDGE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    evtStrobe && chkIn && edgeCfg[chkIdx] |=> irqLine); // R6

  AST_EDGE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    evtStrobe && chkIn && edgeCfg[chkIdx] ##1 !evtStrobe |=> !irqLine); // R6

  AST_LEVEL_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    evtStrobe && chkIn && !edgeCfg[chkIdx] |=> irqLine == $past(polCfg[chkIdx])); // R7

  AST_NO_SPURIOUS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !(evtStrobe && chkIn) |=> !$rose(irqLine)); // R8
endmodule

bind irq_slot_router irqr_chk #(
  .SLOT_W(SLOT_W), .PIN_W(PIN_W), .NUM_W(NUM_W), .CFG_W(CFG_W), .BASE_NUM(BASE_NUM)
) u_chk (.*);

// File: tb/tb_irq_slot_router.sv
module tb_irq_slot_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  slotNum = '0;
  logic [1:0]  pinIdx = '0;
  logic        evtStrobe = 1'b0;
  logic [31:0] edgeCfg = '0;
  logic [31:0] polCfg = '0;
  logic [7:0]  irqNum;
  logic        irqLine;

  int nChecks = 0;
  int nErr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_slot_router dut (.*);

  // {slot[4:0], pin[1:0], expected number[7:0]}
  localparam logic [14:0] VEC [15] = '{
    {5'd5, 2'd0, 8'd32}, {5'd5, 2'd3, 8'd35}, {5'd6, 2'd0, 8'd36},
    {5'd6, 2'd3, 8'd36}, {5'd7, 2'd1, 8'd37}, {5'd7, 2'd2, 8'd37},
    {5'd8, 2'd0, 8'd38}, {5'd8, 2'd3, 8'd41}, {5'd10, 2'd1, 8'd41},
    {5'd12, 2'd0, 8'd42}, {5'd12, 2'd3, 8'd45}, {5'd0, 2'd1, 8'd1},
    {5'd4, 2'd3, 8'd3}, {5'd13, 2'd2, 8'd2}, {5'd31, 2'd0, 8'd0}
  };

  function automatic string reqFor(input logic [4:0] s);
    if (s == 5) return "R2";
    if (s == 6 || s == 7) return "R3";
    if (s >= 8 && s <= 12) return "R4";
    return "R5";
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nErr++;
      nChecks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    // R1: reset holds line low
    tick();
    chk("R1 during reset", irqLine, 0);
    rst_n = 1'b1;
    tick();
    chk("R1 after release", irqLine, 0);

    // Mapping table: R2 R3 R4 R5
    for (int i = 0; i < 15; i++) begin
      slotNum = VEC[i][14:10];
      pinIdx  = VEC[i][9:8];
      #1;
      chk(reqFor(VEC[i][14:10]), irqNum, VEC[i][7:0]);
    end

    // R6: edge pulse on slot 5 pin 1 (index 1)
    slotNum = 5'd5; pinIdx = 2'd1; edgeCfg = 32'h2; polCfg = 32'h0;
    evtStrobe = 1'b1;
    tick();
    evtStrobe = 1'b0;
    chk("R6 pulse cycle", irqLine, 1);
    tick();
    chk("R6 pulse end", irqLine, 0);
    tick();
    chk("R6 stays low", irqLine, 0);

    // R7: level on slot 6 (index 4) with polarity 1, then hold
    slotNum = 5'd6; pinIdx = 2'd2; edgeCfg = 32'h0; polCfg = 32'h10;
    evtStrobe = 1'b1;
    tick();
    evtStrobe = 1'b0;
    chk("R7 level high", irqLine, 1);
    polCfg = 32'h0;
    tick(); tick(); tick();
    chk("R7 holds without strobe", irqLine, 1);

    // R8: untranslated slot with all-edge config does not touch a high line
    slotNum = 5'd3; pinIdx = 2'd2; edgeCfg = 32'hFFFF_FFFF;
    evtStrobe = 1'b1;
    tick();
    evtStrobe = 1'b0;
    chk("R8 high line unchanged", irqLine, 1);
    tick();
    chk("R8 high line unchanged later", irqLine, 1);

    // R7: level strobe with polarity 0 drives low
    slotNum = 5'd6; edgeCfg = 32'h0; polCfg = 32'h0;
    evtStrobe = 1'b1;
    tick();
    evtStrobe = 1'b0;
    chk("R7 level low", irqLine, 0);

    // R8: untranslated slot on a low line, slot 20
    slotNum = 5'd20; pinIdx = 2'd0; edgeCfg = 32'hFFFF_FFFF; polCfg = 32'hFFFF_FFFF;
    evtStrobe = 1'b1;
    tick();
    evtStrobe = 1'b0;
    chk("R8 low line unchanged", irqLine, 0);

    // R9: edge on slot 12 pin 3 (index 13), then level on slot 7 (index 5) in the pulse cycle
    slotNum = 5'd12; pinIdx = 2'd3; edgeCfg = 32'h0000_2000; polCfg = 32'h20;
    evtStrobe = 1'b1;
    tick();
    chk("R6 add-in pulse", irqLine, 1);
    slotNum = 5'd7; pinIdx = 2'd0;
    tick();
    evtStrobe = 1'b0;
    chk("R9 level overrides pulse", irqLine, 1);
    tick();
    chk("R9 no pulse drop", irqLine, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule